// File: doc/BRIEF.md
# Real-Time Clock with Alarm

This block keeps time of day from a slow reference clock. A prescaler divides the reference by one of two ratios to make a one-second tick, and each tick advances a seconds counter. Every tick raises a seconds flag. A tick that brings the counter to a programmed alarm value also raises an alarm flag. Each flag can drive the single interrupt output, and software clears the flags by writing ones to them.

Software reaches the block through a simple synchronous register bus that runs on the reference clock. Reads return data combinationally. The control/status register, the seconds counter, the sub-second prescaler value and the alarm value are each guarded by a separate key register. A register accepts writes only after its key register has been written with the unlock word. The power-on reset input only relocks the keys. Time, configuration and flags keep their values through it, so software must initialise them.

Address map (addr[2:0]): 0 control/status, 1 seconds, 2 prescaler value, 3 alarm, 4 to 7 key registers for addresses 0 to 3. Control/status bits: 0 count enable, 1 freeze enable, 2 alarm interrupt enable, 3 seconds interrupt enable, 4 divide select (0 gives 8192, 1 gives 9600), 6 alarm flag, 7 seconds flag, 15:8 interrupt level.

Top module: `rtc_alarm_top`

## Requirements
- R1: With count enable set, freeze inactive and divide select 0, the seconds value rises by one every 8192 clock cycles.
- R2: With divide select 1, the seconds value rises by one every 9600 clock cycles.
- R3: With count enable 0 the time does not advance. With freeze enable 1 and `freeze` high the time does not advance. With freeze enable 0, `freeze` has no effect.
- R4: Every seconds tick sets the seconds flag (control bit 7). `irq` reflects that flag only while the seconds interrupt enable (bit 3) is 1.
- R5: A tick that makes the seconds value equal to the alarm register sets the alarm flag (bit 6). With alarm interrupt enable (bit 2) set, `irq` goes high.
- R6: Writing 1 to bit 6 or bit 7 of control/status clears that flag, and writing 0 leaves it unchanged. `irq` falls once no enabled flag remains.
- R7: After `por_n` is pulsed low, all four guarded registers are locked, and writes to a locked register leave its contents unchanged.
- R8: Writing 0x55CC_AA33 to a key register (address 4+n) unlocks register n. Writing any other value to it locks register n again.
- R9: Writing the seconds register clears the prescaler, so the next tick comes one full divide period after the write, even while counting.
- R10: The seconds value and configuration are not changed by `por_n`.
- R11: Control bits 15:8 hold an 8-bit interrupt level that reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (also the bus clock) |
| por_n | input | 1 | Power-on reset, active low, relocks keys only |
| freeze | input | 1 | Debug freeze request |
| wr_en | input | 1 | Bus write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The divide path is exercised from a stopped prescaler with each ratio, and again by reloading the seconds register in mid-second. Sampling one cycle before and one cycle at the expected edge separates a correct period from an off-by-one period and from a prescaler that a write fails to clear. Freeze is applied with freeze enable both set and clear, which shows whether the gating is qualified. A tick that does not reach the alarm value and a tick that does reach it show the two flags and the masking apart. Locked, unlocked and relocked writes, together with a power-on pulse, show whether the keys protect the registers and whether the time base survives the reset.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
   localparam logic [31:0] UNLOCK_WORD = 32'h55CC_AA33;
   localparam int NREG = 4;

   typedef enum logic [1:0] {
      R_CTRL  = 2'd0,
      R_TIME  = 2'd1,
      R_FRAC  = 2'd2,
      R_ALARM = 2'd3
   } reg_e;

   localparam int B_EN   = 0;
   localparam int B_FRZ  = 1;
   localparam int B_AIE  = 2;
   localparam int B_SIE  = 3;
   localparam int B_HI   = 4;
   localparam int B_ALM  = 6;
   localparam int B_SEC  = 7;
   localparam int B_LVL  = 8;
   localparam int LVL_W  = 8;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int DIV_LO = 8192,
   parameter int DIV_HI = 9600,
   localparam int DMAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO,
   localparam int PW   = $clog2(DMAX)
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          run,
   input  logic          sel_hi,
   input  logic          load,
   input  logic [PW-1:0] load_val,
   output logic [PW-1:0] cnt,
   output logic          tick
);
   localparam logic [PW-1:0] LIM_LO = PW'(DIV_LO - 1);
   localparam logic [PW-1:0] LIM_HI = PW'(DIV_HI - 1);

   generate
      if (DIV_LO < 2 || DIV_HI < 2) begin : g_bad_div
         $error("rtc_prescaler: divide ratios must be at least 2");
      end
   endgenerate

   logic [PW-1:0] limit;
   assign limit = sel_hi ? LIM_HI : LIM_LO;
   assign tick  = run && !load && (cnt >= limit);

   always_ff @(posedge clk) begin
      if (load)
         cnt <= load_val;
      else if (run)
         cnt <= tick ? '0 : cnt + 1'b1;
   end

   a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (!por_n)
      tick |=> (cnt == '0));

   a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!por_n)
      (!run && !load) |=> $stable(cnt));
endmodule

// File: rtl/rtc_key_lock.sv
module rtc_key_lock #(
   parameter int NREG = 4
) (
   input  logic            clk,
   input  logic            por_n,
   input  logic [NREG-1:0] key_wr,
   input  logic            key_match,
   output logic [NREG-1:0] unlk
);
   generate
      if (NREG < 1) begin : g_bad_n
         $error("rtc_key_lock: NREG must be positive");
      end
      for (genvar i = 0; i < NREG; i++) begin : g_key
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)
               unlk[i] <= 1'b0;
            else if (key_wr[i])
               unlk[i] <= key_match;
         end

         a_r8_key_effect: assert property (@(posedge clk) disable iff (!por_n)
            key_wr[i] |=> (unlk[i] == $past(key_match)));

         a_r8_key_hold: assert property (@(posedge clk) disable iff (!por_n)
            !key_wr[i] |=> $stable(unlk[i]));
      end
   endgenerate
endmodule

// File: rtl/rtc_alarm_top.sv
module rtc_alarm_top
   import rtc_alarm_pkg::*;
#(
   parameter int DIV_LO = 8192,
   parameter int DIV_HI = 9600,
   parameter int SEC_W  = 32,
   parameter int DW     = 32
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          freeze,
   input  logic          wr_en,
   input  logic [2:0]    addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          irq
);
   localparam int DMAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
   localparam int PW   = $clog2(DMAX);

   generate
      if (SEC_W > DW || PW > DW || DW < B_LVL + LVL_W) begin : g_bad_w
         $error("rtc_alarm_top: widths do not fit the bus");
      end
   endgenerate

   logic [NREG-1:0] unlk, key_wr, wr_ok;
   logic            key_match;

   assign key_match = (wdata == UNLOCK_WORD);

   generate
      for (genvar i = 0; i < NREG; i++) begin : g_dec
         assign key_wr[i] = wr_en && addr[2] && (addr[1:0] == i[1:0]);
         assign wr_ok[i]  = wr_en && !addr[2] && (addr[1:0] == i[1:0]) && unlk[i];
      end
   endgenerate

   rtc_key_lock #(.NREG(NREG)) u_keys (
      .clk(clk), .por_n(por_n), .key_wr(key_wr),
      .key_match(key_match), .unlk(unlk)
   );

   // configuration and flags: no reset, software initialises them
   logic             cfg_en, cfg_frz, cfg_aie, cfg_sie, cfg_hi;
   logic [LVL_W-1:0] cfg_lvl;
   logic             flg_sec, flg_alm;
   logic [SEC_W-1:0] sec_q, alarm_q, sec_next;

   logic          run, tick, pre_load;
   logic [PW-1:0] pcnt, pre_val;

   assign run      = cfg_en && !(cfg_frz && freeze);
   assign pre_load = wr_ok[R_TIME] || wr_ok[R_FRAC];
   assign pre_val  = wr_ok[R_TIME] ? '0 : wdata[PW-1:0];

   rtc_prescaler #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_pre (
      .clk(clk), .por_n(por_n), .run(run), .sel_hi(cfg_hi),
      .load(pre_load), .load_val(pre_val), .cnt(pcnt), .tick(tick)
   );

   assign sec_next = sec_q + 1'b1;

   always_ff @(posedge clk) begin
      if (wr_ok[R_TIME])
         sec_q <= wdata[SEC_W-1:0];
      else if (tick)
         sec_q <= sec_next;

      if (wr_ok[R_ALARM])
         alarm_q <= wdata[SEC_W-1:0];

      if (wr_ok[R_CTRL]) begin
         cfg_en  <= wdata[B_EN];
         cfg_frz <= wdata[B_FRZ];
         cfg_aie <= wdata[B_AIE];
         cfg_sie <= wdata[B_SIE];
         cfg_hi  <= wdata[B_HI];
         cfg_lvl <= wdata[B_LVL +: LVL_W];
      end

      flg_sec <= tick || (flg_sec && !(wr_ok[R_CTRL] && wdata[B_SEC]));
      flg_alm <= (tick && (sec_next == alarm_q)) ||
                 (flg_alm && !(wr_ok[R_CTRL] && wdata[B_ALM]));
   end

   assign irq = (flg_sec && cfg_sie) || (flg_alm && cfg_aie);

   logic [DW-1:0] ctrl_rd;
   always_comb begin
      ctrl_rd = '0;
      ctrl_rd[B_EN]  = cfg_en;
      ctrl_rd[B_FRZ] = cfg_frz;
      ctrl_rd[B_AIE] = cfg_aie;
      ctrl_rd[B_SIE] = cfg_sie;
      ctrl_rd[B_HI]  = cfg_hi;
      ctrl_rd[B_ALM] = flg_alm;
      ctrl_rd[B_SEC] = flg_sec;
      ctrl_rd[B_LVL +: LVL_W] = cfg_lvl;
   end

   always_comb begin
      rdata = '0;
      if (!addr[2]) begin
         case (addr[1:0])
            R_CTRL:  rdata = ctrl_rd;
            R_TIME:  rdata[SEC_W-1:0] = sec_q;
            R_FRAC:  rdata[PW-1:0] = pcnt;
            default: rdata[SEC_W-1:0] = alarm_q;
         endcase
      end
   end

   a_r4_tick_sets_flag: assert property (@(posedge clk) disable iff (!por_n)
      tick |=> flg_sec);

   a_r5_alarm_sets_flag: assert property (@(posedge clk) disable iff (!por_n)
      (tick && (sec_next == alarm_q)) |=> flg_alm);

   a_r6_no_flag_no_irq: assert property (@(posedge clk) disable iff (!por_n)
      (!flg_sec && !flg_alm) |-> !irq);

   a_r7_locked_time_kept: assert property (@(posedge clk) disable iff (!por_n)
      (wr_en && addr == 3'd1 && !unlk[R_TIME] && !tick) |=> $stable(sec_q));

   a_r9_write_clears_pre: assert property (@(posedge clk) disable iff (!por_n)
      wr_ok[R_TIME] |=> (pcnt == '0));
endmodule

// File: tb/rtc_alarm_top_tb_top.sv
module rtc_alarm_top_tb_top;
   localparam logic [31:0] KEY = 32'h55CC_AA33;
   localparam logic [31:0] EN = 32'h1, FRZ = 32'h2, AIE = 32'h4, SIE = 32'h8,
                           HI = 32'h10, CLR = 32'hC0;

   logic        clk = 1'b0;
   logic        por_n = 1'b1;
   logic        freeze = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr = 3'd0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;

   rtc_alarm_top dut_i (
      .clk(clk), .por_n(por_n), .freeze(freeze), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   always #4 clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      addr = a;
      #1;
      v = rdata;
   endtask

   task automatic unlock_all();
      for (int i = 4; i < 8; i++) wr(3'(i), KEY);
   endtask

   // stop, load time, then start with cfg; prescaler starts from zero
   task automatic start(input logic [31:0] cfg, input logic [31:0] t);
      wr(3'd0, CLR);
      wr(3'd1, t);
      wr(3'd0, cfg | CLR);
   endtask

   task automatic t_lock_after_por();
      logic [31:0] v0, v1;
      por_n = 1'b0;
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
      rd(3'd1, v0);
      wr(3'd1, 32'h1234);
      rd(3'd1, v1);
      check("R7 locked time write ignored", v1, v0);
      rd(3'd3, v0);
      wr(3'd3, 32'hABCD);
      rd(3'd3, v1);
      check("R7 locked alarm write ignored", v1, v0);
   endtask

   task automatic t_unlock();
      logic [31:0] v;
      unlock_all();
      wr(3'd0, CLR);
      wr(3'd1, 32'd55);
      rd(3'd1, v);
      check("R8 unlocked time write", v, 32'd55);
      rd(3'd0, v);
      check("R6 flags clear after init", v & CLR, 32'h0);
   endtask

   task automatic t_div_lo();
      logic [31:0] v;
      start(EN | SIE, 32'd20);
      repeat (8191) @(negedge clk);
      rd(3'd1, v);
      check("R1 no tick before 8192", v, 32'd20);
      check("R4 irq low before tick", {31'b0, irq}, 32'd0);
      @(negedge clk);
      rd(3'd1, v);
      check("R1 tick at 8192", v, 32'd21);
      rd(3'd0, v);
      check("R4 seconds flag set", v & 32'h80, 32'h80);
      check("R4 irq with seconds enable", {31'b0, irq}, 32'd1);
      repeat (3000) @(negedge clk);
      wr(3'd1, 32'd100);
      repeat (8191) @(negedge clk);
      rd(3'd1, v);
      check("R9 no early tick after reload", v, 32'd100);
      @(negedge clk);
      rd(3'd1, v);
      check("R9 tick full period after reload", v, 32'd101);
   endtask

   task automatic t_div_hi();
      logic [31:0] v;
      start(EN | HI, 32'd0);
      repeat (9599) @(negedge clk);
      rd(3'd1, v);
      check("R2 no tick before 9600", v, 32'd0);
      @(negedge clk);
      rd(3'd1, v);
      check("R2 tick at 9600", v, 32'd1);
   endtask

   task automatic t_freeze();
      logic [31:0] v;
      start(32'h0, 32'd3);
      repeat (9000) @(negedge clk);
      rd(3'd1, v);
      check("R3 disabled does not count", v, 32'd3);
      freeze = 1'b1;
      start(EN | FRZ, 32'd5);
      repeat (9000) @(negedge clk);
      rd(3'd1, v);
      check("R3 frozen does not count", v, 32'd5);
      wr(3'd0, EN);
      repeat (8191) @(negedge clk);
      rd(3'd1, v);
      check("R3 freeze ignored, before tick", v, 32'd5);
      @(negedge clk);
      rd(3'd1, v);
      check("R3 freeze ignored, tick", v, 32'd6);
      freeze = 1'b0;
   endtask

   task automatic t_alarm();
      logic [31:0] v;
      wr(3'd3, 32'd10);
      start(EN | AIE, 32'd6);
      repeat (8192) @(negedge clk);
      rd(3'd0, v);
      check("R5 no alarm off match", v & 32'h40, 32'h0);
      check("R4 seconds flag masked from irq", {31'b0, irq}, 32'd0);
      wr(3'd1, 32'd9);
      repeat (8192) @(negedge clk);
      rd(3'd1, v);
      check("R5 time reached alarm", v, 32'd10);
      rd(3'd0, v);
      check("R5 alarm flag set", v & 32'h40, 32'h40);
      check("R5 irq on alarm", {31'b0, irq}, 32'd1);
      wr(3'd0, EN | AIE);
      rd(3'd0, v);
      check("R6 writing zero keeps flags", v & CLR, CLR);
      wr(3'd0, EN | AIE | 32'h40);
      rd(3'd0, v);
      check("R6 alarm flag cleared only", v & CLR, 32'h80);
      check("R6 irq drops after clear", {31'b0, irq}, 32'd0);
      wr(3'd0, EN | AIE | 32'h80);
      rd(3'd0, v);
      check("R6 seconds flag cleared", v & CLR, 32'h0);
   endtask

   task automatic t_level();
      logic [31:0] v;
      wr(3'd0, 32'h0000_A500 | CLR);
      rd(3'd0, v);
      check("R11 level field", v[15:8], 32'hA5);
   endtask

   task automatic t_relock_survive();
      logic [31:0] v;
      wr(3'd1, 32'd42);
      wr(3'd5, 32'h0);
      wr(3'd1, 32'd77);
      rd(3'd1, v);
      check("R8 relocked write ignored", v, 32'd42);
      por_n = 1'b0;
      repeat (2) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
      rd(3'd1, v);
      check("R10 time survives por", v, 32'd42);
      rd(3'd0, v);
      check("R10 level survives por", v[15:8], 32'hA5);
      wr(3'd0, 32'h0);
      rd(3'd0, v);
      check("R7 ctrl locked after por", v[15:8], 32'hA5);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      t_lock_after_por();
      t_unlock();
      t_div_lo();
      t_div_hi();
      t_freeze();
      t_alarm();
      t_level();
      t_relock_survive();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule